// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer for a small microcontroller. Software sets it up through a byte-wide register port. An 8-bit down counter decrements once per prescaler period. The prescaler divides the selected count source by one of eight powers of two. The count source is either every CPU clock cycle or a strobe from a separate watchdog oscillator, which arrives as the `osc_tick` clock-enable input.

Software proves it is alive by feeding the counter. A feed is a key of A5h written to the first key register, followed by a key of 5Ah written to the second key register as the very next write. A completed feed reloads the counter from the load register and clears the prescaler.

If the counter expires while counting is enabled, the block does three things in the same clock edge:
- it issues a single-cycle reset request;
- it returns its own registers to their defaults;
- it sets a timeout flag.

The flag tells software, after reset, whether the watchdog caused the last reset. A power-on reset clears the flag. Any other system reset keeps it.

Top module: `wdt_prescaled`

## Requirements
- R1: `por_n` low is an asynchronous reset. Once it is released, the control register reads E5h, the load register reads FFh and `wdt_rst_o` is 0.
- R2: When the counter expires, the block resets its own registers and sets the timeout flag. The control register then reads E7h and the load register reads FFh.
- R3: `other_rst` high at a clock edge restores the defaults for the prescaler select, the run bit, the source select and the load register (FFh), and leaves the timeout flag unchanged.
- R4: With the CPU clock as source, `wdt_rst_o` rises in the cycle after clock edge number (L+1)·2^(5+S), counted from the edge that completed the feed. L is the load value and S is the 3-bit prescaler select.
- R5: While the run bit is 0, neither the prescaler nor the counter advances. Counting resumes from the held state once the run bit is set again.
- R6: With the source select set to 1, the prescaler advances only on cycles where `osc_tick` is 1. With the source select at 0, it advances on every cycle.
- R7: A write of A5h to address 2 followed, as the next write, by a write of 5Ah to address 3 reloads the counter from the load register and clears the prescaler.
- R8: A wrong key value, a second-key write without the first, or any other write between the two keys cancels the feed, and the running count is unaffected.
- R9: `wdt_rst_o` is high for exactly one clock cycle per expiry.
- R10: The control register is at address 0, with these fields:
  - bits 7:5: prescaler select;
  - bit 2: run;
  - bit 1: timeout flag, which software can write;
  - bit 0: source select;
  - bits 4:3: always read as 0.

  The load register is at address 1 and reads back what was written. A new load value takes effect only at the next feed. The key registers at addresses 2 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (CPU clock) |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| other_rst | input | 1 | Any non-power-on system reset, synchronous, active high |
| osc_tick | input | 1 | One-cycle enable from the watchdog oscillator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 ctrl, 1 load, 2 key 1, 3 key 2) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| wdt_rst_o | output | 1 | Single-cycle reset request on expiry |

## Verification
A counter or prescaler that holds a wrong value shows up only as a timeout that comes at the wrong time. The bench therefore measures the number of cycles from each feed to `wdt_rst_o`, which exposes an off-by-one in either stage within one watchdog period. A feed checker that accepts a broken key sequence shows up as a missing or late timeout. The bench times each cancelled feed against the original feed to catch this. Errors in the flag and in the defaults are visible on the register read port straight after each kind of reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LOAD = 2'd1,
    REG_KEY1 = 2'd2,
    REG_KEY2 = 2'd3
  } wd_reg_e;

  localparam logic [DATA_W-1:0] KEY1_VAL = 8'hA5;
  localparam logic [DATA_W-1:0] KEY2_VAL = 8'h5A;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst,
  input  logic              fire,
  input  logic              wr_en,
  input  wd_reg_e           wr_sel,
  input  logic [PSEL_W+2:0] ctrl_wdata,
  input  logic [DATA_W-1:0] load_wdata,
  input  wd_reg_e           rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [PSEL_W-1:0] psel_q,
  output logic              run_q,
  output logic              tmo_q,
  output logic              csel_q,
  output logic [DATA_W-1:0] load_q
);
  localparam int RSVD_W = DATA_W - PSEL_W - 3;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      psel_q <= '1;
      run_q  <= 1'b1;
      csel_q <= 1'b1;
      tmo_q  <= 1'b0;
      load_q <= '1;
    end else if (soft_rst) begin
      psel_q <= '1;
      run_q  <= 1'b1;
      csel_q <= 1'b1;
      load_q <= '1;
    end else if (fire) begin
      psel_q <= '1;
      run_q  <= 1'b1;
      csel_q <= 1'b1;
      tmo_q  <= 1'b1;
      load_q <= '1;
    end else if (wr_en && wr_sel == REG_CTRL) begin
      psel_q <= ctrl_wdata[PSEL_W+2:3];
      run_q  <= ctrl_wdata[2];
      tmo_q  <= ctrl_wdata[1];
      csel_q <= ctrl_wdata[0];
    end else if (wr_en && wr_sel == REG_LOAD) begin
      load_q <= load_wdata;
    end
  end

  always_comb begin
    case (rd_sel)
      REG_CTRL: rd_data = {psel_q, {RSVD_W{1'b0}}, run_q, tmo_q, csel_q};
      REG_LOAD: rd_data = load_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdt_feed.sv
module wdt_feed
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst,
  input  logic              fire,
  input  logic              wr_en,
  input  wd_reg_e           wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              feed_ok
);
  logic armed_q;

  assign feed_ok = wr_en && armed_q && wr_sel == REG_KEY2 && wr_data == KEY2_VAL;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              armed_q <= 1'b0;
    else if (soft_rst || fire) armed_q <= 1'b0;
    else if (wr_en)          armed_q <= (wr_sel == REG_KEY1) && (wr_data == KEY1_VAL);
  end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int PSEL_W    = 3,
  parameter int BASE_LOG2 = 5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              clr,
  input  logic              step,
  input  logic [PSEL_W-1:0] psel,
  output logic              dec_tick
);
  localparam int NSEL = 1 << PSEL_W;
  localparam int PW   = BASE_LOG2 + NSEL - 1;

  logic [PW-1:0]   pre_q;
  logic [NSEL-1:0] term;

  for (genvar g = 0; g < NSEL; g++) begin : g_term
    assign term[g] = &pre_q[BASE_LOG2+g-1:0];
  end

  assign dec_tick = step & term[psel];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                pre_q <= '0;
    else if (clr || dec_tick)  pre_q <= '0;
    else if (step)             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst,
  input  logic              feed_ok,
  input  logic              dec_tick,
  input  logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic              fire,
  output logic              pulse_q
);
  assign fire = dec_tick && (cnt_q == '0) && !soft_rst;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                cnt_q <= '1;
    else if (soft_rst || fire) cnt_q <= '1;
    else if (feed_ok)          cnt_q <= load_q;
    else if (dec_tick)         cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) pulse_q <= 1'b0;
    else        pulse_q <= fire;
  end
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
  import wdt_pkg::*;
#(
  parameter int PSEL_W    = 3,
  parameter int BASE_LOG2 = 5
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        other_rst,
  input  logic        osc_tick,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic        wdt_rst_o
);
  logic [PSEL_W-1:0] psel_q;
  logic              run_q, tmo_q, csel_q;
  logic [DATA_W-1:0] load_q, cnt_q;
  logic              feed_ok, fire, dec_tick, step, src_tick;
  logic [PSEL_W+2:0] ctrl_wdata;
  wd_reg_e           wr_sel, rd_sel;

  assign wr_sel     = wd_reg_e'(wr_addr);
  assign rd_sel     = wd_reg_e'(rd_addr);
  assign ctrl_wdata = {wr_data[DATA_W-1 -: PSEL_W], wr_data[2:0]};
  assign src_tick   = csel_q ? osc_tick : 1'b1;
  assign step       = run_q & src_tick;

  wdt_regs #(.PSEL_W(PSEL_W)) u_regs (
    .clk(clk), .por_n(por_n), .soft_rst(other_rst), .fire(fire),
    .wr_en(wr_en), .wr_sel(wr_sel), .ctrl_wdata(ctrl_wdata), .load_wdata(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .psel_q(psel_q), .run_q(run_q), .tmo_q(tmo_q), .csel_q(csel_q), .load_q(load_q)
  );

  wdt_feed u_feed (
    .clk(clk), .por_n(por_n), .soft_rst(other_rst), .fire(fire),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .feed_ok(feed_ok)
  );

  wdt_prescale #(.PSEL_W(PSEL_W), .BASE_LOG2(BASE_LOG2)) u_pre (
    .clk(clk), .por_n(por_n), .clr(other_rst | fire | feed_ok),
    .step(step), .psel(psel_q), .dec_tick(dec_tick)
  );

  wdt_count u_cnt (
    .clk(clk), .por_n(por_n), .soft_rst(other_rst), .feed_ok(feed_ok),
    .dec_tick(dec_tick), .load_q(load_q), .cnt_q(cnt_q), .fire(fire),
    .pulse_q(wdt_rst_o)
  );
endmodule

// File: rtl/wdt_checks.sv
module wdt_checks (
  input logic       clk,
  input logic       por_n,
  input logic       other_rst,
  input logic       wdt_rst_o,
  input logic       tmo,
  input logic       run,
  input logic [7:0] cnt,
  input logic [7:0] load,
  input logic       feed_ok,
  input logic       fire,
  input logic       dec_tick
);
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rst_o |=> !wdt_rst_o);

  p_flag_on_expiry_r2: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rst_o |-> tmo);

  p_flag_kept_r3: assert property (@(posedge clk) disable iff (!por_n)
    other_rst |=> $stable(tmo));

  p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!por_n)
    (!run && !feed_ok && !other_rst) |=> $stable(cnt));

  p_feed_reload_r7: assert property (@(posedge clk) disable iff (!por_n)
    (feed_ok && !fire && !other_rst) |=> cnt == $past(load));

  p_step_down_r4: assert property (@(posedge clk) disable iff (!por_n)
    (dec_tick && cnt != 8'd0 && !feed_ok && !other_rst) |=> cnt == $past(cnt) - 8'd1);
endmodule

bind wdt_prescaled wdt_checks u_chk (
  .clk(clk), .por_n(por_n), .other_rst(other_rst), .wdt_rst_o(wdt_rst_o),
  .tmo(tmo_q), .run(run_q), .cnt(cnt_q), .load(load_q),
  .feed_ok(feed_ok), .fire(fire), .dec_tick(dec_tick)
);

// File: tb/sim_wdt_prescaled.sv
module sim_wdt_prescaled;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       other_rst = 1'b0;
  logic       osc_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       wdt_rst_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t_feed = 0;

  wdt_prescaled u0 (
    .clk(clk), .por_n(por_n), .other_rst(other_rst), .osc_tick(osc_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wdt_rst_o(wdt_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_period(input int ld, input int sel);
    return (ld + 1) << (5 + sel);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic feed();
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
    t_feed = cyc;
  endtask

  task automatic wait_pulse(input int max, output int el);
    el = -1;
    for (int k = 0; k < max; k++) begin
      if (wdt_rst_o) begin
        el = cyc - t_feed;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic pulse_other_rst();
    other_rst = 1'b1;
    @(negedge clk);
    other_rst = 1'b0;
  endtask

  task automatic idle_no_pulse(input int n, inout int seen);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (wdt_rst_o) seen++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, el, seen;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 8'hE5);
    rd(2'd1, v); chk("R1 load", v, 8'hFF);
    chk("R1 pulse", int'(wdt_rst_o), 0);
    rd(2'd2, v); chk("R10 key read", v, 0);

    // R4/R7 directed: sel 0, load 3, cpu clock
    wr(2'd0, 8'h04); wr(2'd1, 8'h03); feed();
    wait_pulse(5000, el); chk("R4 period", el, exp_period(3, 0));
    @(negedge clk); chk("R9 pulse width", int'(wdt_rst_o), 0);
    rd(2'd0, v); chk("R2 ctrl after expiry", v, 8'hE7);
    rd(2'd1, v); chk("R2 load after expiry", v, 8'hFF);

    // R3 / R10
    pulse_other_rst();
    rd(2'd0, v); chk("R3 flag kept 1", v, 8'hE7);
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R10 reserved zero", v, 8'hE7);
    wr(2'd0, 8'h00); rd(2'd0, v); chk("R10 ctrl readback", v, 8'h00);
    wr(2'd1, 8'h3C); rd(2'd1, v); chk("R10 load readback", v, 8'h3C);
    pulse_other_rst();
    rd(2'd0, v); chk("R3 flag kept 0", v, 8'hE5);
    rd(2'd1, v); chk("R3 load default", v, 8'hFF);

    // R4 random
    for (int t = 0; t < 6; t++) begin
      int sel, ld;
      sel = $urandom_range(0, 2);
      ld  = $urandom_range(0, 7);
      wr(2'd0, {sel[2:0], 5'b00100}); wr(2'd1, ld[7:0]); feed();
      wait_pulse(5000, el); chk("R4 random period", el, exp_period(ld, sel));
      @(negedge clk); chk("R9 random width", int'(wdt_rst_o), 0);
    end

    // R8 intervening write cancels feed; R10 load applies only at feed
    wr(2'd0, 8'h04); wr(2'd1, 8'h09); feed();
    repeat (100) @(negedge clk);
    wr(2'd2, 8'hA5); wr(2'd1, 8'h01); wr(2'd3, 8'h5A);
    rd(2'd1, v); chk("R10 load written", v, 8'h01);
    wait_pulse(5000, el); chk("R8 intervening write", el, exp_period(9, 0));

    // R8 wrong second key
    wr(2'd0, 8'h04); wr(2'd1, 8'h09); feed();
    repeat (100) @(negedge clk);
    wr(2'd2, 8'hA5); wr(2'd3, 8'h5B);
    wait_pulse(5000, el); chk("R8 wrong key", el, exp_period(9, 0));

    // R8 second key alone
    wr(2'd0, 8'h04); wr(2'd1, 8'h09); feed();
    repeat (100) @(negedge clk);
    wr(2'd3, 8'h5A);
    wait_pulse(5000, el); chk("R8 lone key", el, exp_period(9, 0));

    // R7 valid refeed restarts the period
    wr(2'd0, 8'h04); wr(2'd1, 8'h09); feed();
    repeat (100) @(negedge clk);
    feed();
    wait_pulse(5000, el); chk("R7 refeed", el, exp_period(9, 0));

    // R5 run bit freezes counting
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); feed();
    seen = 0;
    idle_no_pulse(100, seen);
    chk("R5 no expiry while stopped", seen, 0);
    wr(2'd0, 8'h04); t_feed = cyc;
    wait_pulse(5000, el); chk("R5 resume", el, 32);

    // R6 oscillator source
    wr(2'd0, 8'h05); wr(2'd1, 8'h00); feed();
    seen = 0;
    for (int k = 1; k <= 32; k++) begin
      osc_tick = 1'b1;
      @(negedge clk);
      osc_tick = 1'b0;
      if (k < 32) begin
        if (wdt_rst_o) seen++;
        idle_no_pulse(2, seen);
      end else begin
        chk("R6 expiry on 32nd tick", int'(wdt_rst_o), 1);
      end
    end
    chk("R6 no early expiry", seen, 0);

    // R1 power-on clears the flag
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 flag cleared by power-on", v, 8'hE5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule